// File: doc/BRIEF.md
# DDR Write Burst Timing Sequencer

This block sits on the controller side of a DDR4-style memory interface. It turns each accepted write command into a write-data burst with the right timing. When a command strobe is sampled, the block captures the burst-mode, additive-latency and write-latency settings. From the burst-mode setting and the command's length bit it works out how long the burst is. It then marks the clocks, a fixed number of clocks later, in which data beats must be driven. Data is double rate: every data clock carries a rising-half beat and a falling-half beat. So an 8-beat burst takes 4 clocks and a 4-beat chop takes 2.

Around each run of data clocks the block raises a strobe output enable, with one preamble clock before the run and one postamble clock after it. It emits a one-clock reference pulse on the first clock after the run's last data clock, which starts the write-recovery and write-to-read timers. Write data is pulled from a FIFO through a valid/ready pair.

The block applies no back-pressure to commands. A command that comes too soon after the previous one raises a sticky flag and is still scheduled.

Top module: `wrburst_seq`

## Requirements
- R1: Take a command accepted in clock c. Its first data clock is c+W, where W = mode_addlat + mode_wrlat, and W is raised to 2 when the sum is smaller than 2.
- R2: When mode_burst is 2'b10, every burst is a 4-beat chop (2 data clocks), whatever the value of cmd_long.
- R3: When mode_burst is 2'b01, cmd_long=1 gives 4 data clocks and cmd_long=0 gives 2. When mode_burst is 2'b00 or 2'b11, every burst takes 4 data clocks.
- R4: strobe_oe is high in every data clock, in the clock just before a run of data clocks (preamble) and in the clock just after it (postamble). It is low in every other clock.
- R5: Two bursts whose data clocks adjoin form one run, with no idle clock between them. There is no preamble or postamble at the joint, so strobe_oe stays high across it.
- R6: wr_ref_pulse is high for exactly the one clock that follows the last data clock of a run.
- R7: src_ready is high in each data clock. In each data clock, dq_rise carries src_data bits [DW-1:0] and dq_fall carries bits [2*DW-1:DW]. Both are zero in other clocks.
- R8: If src_valid is low in a data clock, underflow_err is set and stays set until reset.
- R9: spacing_err is set and stays set until reset when a command arrives less than TCCD_S clocks (default 4) after the previous command to a different bank group, or less than TCCD_L clocks (default 6) after one to the same bank group. The command is still scheduled. Exactly TCCD_S clocks to a different bank group sets no flag.
- R10: While rst_n is low, and in the first clock after it rises, all outputs are low.
- R11: The latency and burst-mode inputs count only in the clock a command is accepted. Changing them later does not move bursts that are already scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write command strobe, one clock per command |
| cmd_bg | input | BG_W | Bank group of the command |
| cmd_long | input | 1 | Per-command length bit (1 = 8 beats, used when mode_burst is 2'b01) |
| mode_burst | input | 2 | Burst mode: 00 fixed 8, 01 per command, 10 fixed chop, 11 treated as fixed 8 |
| mode_addlat | input | LW | Additive latency in clocks |
| mode_wrlat | input | LW | Write latency in clocks |
| src_valid | input | 1 | Write-data FIFO holds a beat pair |
| src_ready | output | 1 | Pops one beat pair from the FIFO |
| src_data | input | 2*DW | Beat pair: low half is the rising beat, high half the falling beat |
| beat_en_rise | output | 1 | Rising-half data beat enable |
| beat_en_fall | output | 1 | Falling-half data beat enable |
| dq_rise | output | DW | Rising-half beat data |
| dq_fall | output | DW | Falling-half beat data |
| strobe_oe | output | 1 | Strobe output enable, including preamble and postamble |
| wr_ref_pulse | output | 1 | Reference edge for the write-recovery and write-to-read timers |
| spacing_err | output | 1 | Sticky command-spacing violation |
| underflow_err | output | 1 | Sticky FIFO underflow during a burst |

## Verification
Two events can fall on the same clock boundary: the end of one burst and the start of the next. In that case the postamble and reference pulse of the first burst must give way to the data of the second. The bench provokes this by sending an 8-beat write and then, exactly four clocks later, a chopped write to another bank group, with the same latency. The expected outcome is six adjoining data clocks and strobe_oe high throughout. There must be a single reference pulse after the last chopped beat and no spacing flag. A scoreboard checks the data beats in order against the FIFO model.

// File: rtl/wrburst_pkg.sv
package wrburst_pkg;
  typedef enum logic [1:0] {
    BM_FIX8 = 2'b00,
    BM_OTF  = 2'b01,
    BM_CHOP = 2'b10,
    BM_RSVD = 2'b11
  } burst_mode_e;

  localparam int unsigned MIN_LAT = 2;
endpackage

// File: rtl/wb_len_sel.sv
module wb_len_sel
  import wrburst_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       long_bit,
  output logic       long_burst
);
  always_comb begin
    unique case (burst_mode_e'(mode))
      BM_OTF:  long_burst = long_bit;
      BM_CHOP: long_burst = 1'b0;
      default: long_burst = 1'b1;
    endcase
  end
endmodule

// File: rtl/wb_timeline.sv
module wb_timeline
  import wrburst_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          long_burst,
  input  logic [LW-1:0] al,
  input  logic [LW-1:0] cwl,
  output logic          busy_now,
  output logic          busy_next,
  output logic          busy_prev
);
  localparam int MAXLAT = (1 << LW) - 1;
  localparam int TL     = 2 * MAXLAT + 4;

  logic [LW:0]   lat_sum;
  logic [LW:0]   lat_eff;
  logic [TL-1:0] new_mask;
  logic [TL-1:0] busy_q;
  logic          prev_q;

  always_comb begin
    lat_sum  = {1'b0, al} + {1'b0, cwl};
    lat_eff  = (lat_sum < (LW+1)'(MIN_LAT)) ? (LW+1)'(MIN_LAT) : lat_sum;
    new_mask = (long_burst ? TL'(4'hF) : TL'(4'h3)) << (lat_eff - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      prev_q <= 1'b0;
    end else begin
      busy_q <= (busy_q >> 1) | (fire ? new_mask : '0);
      prev_q <= busy_q[0];
    end
  end

  assign busy_now  = busy_q[0];
  assign busy_next = busy_q[1];
  assign busy_prev = prev_q;

  // R4: a run of data clocks is always announced one clock ahead
  p_announce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_now && !fire) |=> (busy_now == $past(busy_next)));
endmodule

// File: rtl/wb_spacing.sv
module wb_spacing #(
  parameter int BG_W   = 2,
  parameter int TCCD_S = 4,
  parameter int TCCD_L = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [BG_W-1:0] bg,
  output logic            err
);
  localparam int CW = $clog2(TCCD_L + 1);

  logic [CW-1:0]   gap_q;
  logic [BG_W-1:0] last_bg_q;
  logic            seen_q;
  logic            err_q;
  logic [CW-1:0]   limit;
  logic            too_close;

  always_comb begin
    limit     = (bg == last_bg_q) ? CW'(TCCD_L) : CW'(TCCD_S);
    too_close = fire && seen_q && (gap_q < limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= CW'(TCCD_L);
      last_bg_q <= '0;
      seen_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (fire) begin
        gap_q     <= CW'(1);
        last_bg_q <= bg;
        seen_q    <= 1'b1;
      end else if (gap_q < CW'(TCCD_L)) begin
        gap_q <= gap_q + 1'b1;
      end
      if (too_close) err_q <= 1'b1;
    end
  end

  assign err = err_q;

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/wrburst_seq.sv
module wrburst_seq #(
  parameter int DW     = 8,
  parameter int LW     = 5,
  parameter int BG_W   = 2,
  parameter int TCCD_S = 4,
  parameter int TCCD_L = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [BG_W-1:0] cmd_bg,
  input  logic            cmd_long,
  input  logic [1:0]      mode_burst,
  input  logic [LW-1:0]   mode_addlat,
  input  logic [LW-1:0]   mode_wrlat,
  input  logic            src_valid,
  output logic            src_ready,
  input  logic [2*DW-1:0] src_data,
  output logic            beat_en_rise,
  output logic            beat_en_fall,
  output logic [DW-1:0]   dq_rise,
  output logic [DW-1:0]   dq_fall,
  output logic            strobe_oe,
  output logic            wr_ref_pulse,
  output logic            spacing_err,
  output logic            underflow_err
);
  logic          long_burst;
  logic          busy_now, busy_next, busy_prev;
  logic          uflow_q;
  logic [DW-1:0] half_data [2];

  wb_len_sel u_len (
    .mode       (mode_burst),
    .long_bit   (cmd_long),
    .long_burst (long_burst)
  );

  wb_timeline #(.LW(LW)) u_tl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (cmd_valid),
    .long_burst (long_burst),
    .al         (mode_addlat),
    .cwl        (mode_wrlat),
    .busy_now   (busy_now),
    .busy_next  (busy_next),
    .busy_prev  (busy_prev)
  );

  wb_spacing #(.BG_W(BG_W), .TCCD_S(TCCD_S), .TCCD_L(TCCD_L)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (cmd_valid),
    .bg    (cmd_bg),
    .err   (spacing_err)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_data[h] = busy_now ? src_data[h*DW +: DW] : '0;
  end

  assign dq_rise      = half_data[0];
  assign dq_fall      = half_data[1];
  assign beat_en_rise = busy_now;
  assign beat_en_fall = busy_now;
  assign src_ready    = busy_now;
  assign strobe_oe    = busy_now | busy_next | busy_prev;
  assign wr_ref_pulse = busy_prev & ~busy_now;

  always_ff @(posedge clk) begin
    if (!rst_n)                       uflow_q <= 1'b0;
    else if (busy_now && !src_valid)  uflow_q <= 1'b1;
  end
  assign underflow_err = uflow_q;

  // R4: preamble before the first data clock
  p_preamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(beat_en_rise) |-> $past(strobe_oe));
  // R4: postamble after the last data clock
  p_postamble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(beat_en_rise) |-> strobe_oe);
  // R6: reference pulse only right after a data clock
  p_ref_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ref_pulse |-> (!beat_en_rise && $past(beat_en_rise)));
  // R8: underflow flag is sticky
  p_uflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
endmodule

// File: tb/test_wrburst_seq.sv
module test_wrburst_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_bg = '0;
  logic       cmd_long = 1'b0;
  logic [1:0] mode_burst = 2'b00;
  logic [4:0] mode_addlat = '0;
  logic [4:0] mode_wrlat = 5'd9;
  logic       src_valid = 1'b1;
  logic       src_ready;
  logic [15:0] src_data;
  logic       beat_en_rise, beat_en_fall, strobe_oe, wr_ref_pulse;
  logic       spacing_err, underflow_err;
  logic [7:0] dq_rise, dq_fall;

  wrburst_seq i_wrburst_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bg(cmd_bg),
    .cmd_long(cmd_long), .mode_burst(mode_burst), .mode_addlat(mode_addlat),
    .mode_wrlat(mode_wrlat), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .beat_en_rise(beat_en_rise), .beat_en_fall(beat_en_fall),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .strobe_oe(strobe_oe),
    .wr_ref_pulse(wr_ref_pulse), .spacing_err(spacing_err),
    .underflow_err(underflow_err)
  );

  always #4 clk = ~clk;

  int  cyc = 0;
  int  total = 0;
  int  bad = 0;
  int  src_k = 0;
  int  nb = 0;
  int  beat_clks = 0;
  int  ref_cnt = 0;
  int  oe_low_in_run = 0;
  bit  mon_on = 1'b0;
  bit  done = 1'b0;
  bit  exp_busy [8192];
  int  sb_q [$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rst_n && src_ready && src_valid) src_k <= src_k + 1;
  assign src_data = {8'(2*src_k + 1), 8'(2*src_k)};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%0d exp=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit eb(input int i);
    return (i < 0 || i >= 8192) ? 1'b0 : exp_busy[i];
  endfunction

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: scoreboard pop and per-clock model compare
  always @(negedge clk) begin
    if (mon_on) begin
      chk(beat_en_rise == eb(cyc) && beat_en_fall == eb(cyc), "R1 beat enable",
          int'(beat_en_rise), int'(eb(cyc)));
      chk(strobe_oe == (eb(cyc) | eb(cyc+1) | eb(cyc-1)), "R4 R5 strobe_oe",
          int'(strobe_oe), int'(eb(cyc) | eb(cyc+1) | eb(cyc-1)));
      chk(wr_ref_pulse == (eb(cyc-1) & !eb(cyc)), "R6 ref pulse",
          int'(wr_ref_pulse), int'(eb(cyc-1) & !eb(cyc)));
      if (wr_ref_pulse) ref_cnt++;
      if (eb(cyc-1) && eb(cyc) && !strobe_oe) oe_low_in_run++;
      if (beat_en_rise) begin
        beat_clks++;
        chk(src_ready == 1'b1, "R7 src_ready", int'(src_ready), 1);
        if (sb_q.size() == 0) chk(1'b0, "R1 unexpected beat", cyc, -1);
        else begin
          int want;
          want = sb_q.pop_front();
          chk(want == cyc, "R1 beat clock", cyc, want);
        end
        if (src_valid) begin
          chk(dq_rise == 8'(2*nb) && dq_fall == 8'(2*nb+1), "R7 beat data",
              int'({dq_fall, dq_rise}), int'({8'(2*nb+1), 8'(2*nb)}));
          nb++;
        end
      end else begin
        chk(dq_rise == 8'd0 && dq_fall == 8'd0 && !src_ready, "R7 idle data",
            int'({dq_fall, dq_rise}), 0);
      end
    end
  end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // driver: issues a command and pushes the expected data clocks
  task automatic issue(input logic [1:0] bg, input bit lng, input logic [1:0] mode,
                       input int al, input int cwl);
    int w, nclk;
    bit is_long;
    cmd_valid = 1'b1; cmd_bg = bg; cmd_long = lng;
    mode_burst = mode; mode_addlat = 5'(al); mode_wrlat = 5'(cwl);
    w = al + cwl;
    if (w < 2) w = 2;
    is_long = (mode == 2'b10) ? 1'b0 : (mode == 2'b01) ? lng : 1'b1;
    nclk = is_long ? 4 : 2;
    for (int i = 0; i < nclk; i++) begin
      exp_busy[cyc + w + i] = 1'b1;
      sb_q.push_back(cyc + w + i);
    end
    tick;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick;
  endtask

  initial begin
    int b0, r0;
    // R10: reset state
    idle(3);
    #3;
    chk({beat_en_rise, beat_en_fall, strobe_oe, wr_ref_pulse, src_ready,
         spacing_err, underflow_err} == 7'd0, "R10 reset outputs", 1, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    #3;
    chk({strobe_oe, src_ready, spacing_err, underflow_err, dq_rise, dq_fall} == '0,
        "R10 after reset", int'(strobe_oe), 0);
    mon_on = 1'b1;
    tick;

    // R3: fixed-8 mode ignores the length bit
    b0 = beat_clks;
    issue(2'd0, 1'b0, 2'b00, 0, 9); idle(16);
    chk(beat_clks - b0 == 4, "R3 fixed 8 clocks", beat_clks - b0, 4);

    // R2: fixed chop ignores the length bit
    b0 = beat_clks;
    issue(2'd1, 1'b1, 2'b10, 0, 9); idle(16);
    chk(beat_clks - b0 == 2, "R2 chop clocks", beat_clks - b0, 2);

    // R3: per-command length
    b0 = beat_clks;
    issue(2'd2, 1'b1, 2'b01, 0, 9); idle(16);
    chk(beat_clks - b0 == 4, "R3 otf long", beat_clks - b0, 4);
    b0 = beat_clks;
    issue(2'd3, 1'b0, 2'b01, 0, 9); idle(16);
    chk(beat_clks - b0 == 2, "R3 otf chop", beat_clks - b0, 2);

    // R5: seamless 8 then chop, different bank group, 4 clocks apart
    b0 = beat_clks; r0 = ref_cnt; oe_low_in_run = 0;
    issue(2'd0, 1'b1, 2'b01, 0, 9); idle(3);
    issue(2'd1, 1'b0, 2'b01, 0, 9); idle(18);
    chk(beat_clks - b0 == 6, "R5 joined run length", beat_clks - b0, 6);
    chk(ref_cnt - r0 == 1, "R5 R6 single ref pulse", ref_cnt - r0, 1);
    chk(oe_low_in_run == 0, "R5 strobe held", oe_low_in_run, 0);
    chk(spacing_err == 1'b0, "R9 tCCD_S legal", int'(spacing_err), 0);

    // R1: additive latency and the lower clamp
    issue(2'd2, 1'b1, 2'b00, 3, 5); idle(16);
    b0 = beat_clks;
    issue(2'd3, 1'b0, 2'b10, 0, 1); idle(8);
    chk(beat_clks - b0 == 2, "R1 clamped latency burst", beat_clks - b0, 2);
    issue(2'd0, 1'b1, 2'b00, 0, 0); idle(8);

    // R11: mode change after acceptance does not move the burst
    issue(2'd1, 1'b1, 2'b00, 2, 9);
    mode_addlat = 5'd0; mode_wrlat = 5'd3; mode_burst = 2'b10;
    idle(20);
    chk(ref_cnt > 0 && spacing_err == 1'b0, "R11 no side effects", int'(spacing_err), 0);

    // R9: same bank group 4 clocks apart is a violation but still runs
    chk(underflow_err == 1'b0, "R8 no false underflow", int'(underflow_err), 0);
    b0 = beat_clks;
    issue(2'd2, 1'b1, 2'b00, 0, 9); idle(3);
    issue(2'd2, 1'b1, 2'b00, 0, 9); idle(20);
    chk(spacing_err == 1'b1, "R9 same group too close", int'(spacing_err), 1);
    chk(beat_clks - b0 == 8, "R9 still scheduled", beat_clks - b0, 8);

    // R8: underflow during a burst
    src_valid = 1'b0;
    issue(2'd3, 1'b0, 2'b10, 0, 4); idle(10);
    src_valid = 1'b1;
    chk(underflow_err == 1'b1, "R8 underflow flagged", int'(underflow_err), 1);
    idle(3);
    chk(underflow_err == 1'b1, "R8 underflow sticky", int'(underflow_err), 1);
    chk(sb_q.size() == 0, "R1 all beats seen", sb_q.size(), 0);

    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      finish_up();
    end
  end
endmodule